// File: doc/BRIEF.md
# Lockable Clock Post-Divider with Ratio Register

This block divides a fast source clock by a programmable integer from 1 to 16 to produce a base clock. It also holds a 6-bit feedback ratio for an external PLL. Both ratios live in byte-wide registers behind a simple write/read port. Register 0 holds the post-divide code and register 1 holds the feedback code. Reads are combinational on the cycle the read strobe is high.

Writes to the ratio registers are refused while the clock-source select says the PLL is driving the chip. This stops software from retuning a clock that is already in use. The hard reset clears everything. The soft reset keeps the ratio fields and restarts only the divider.

A new post-divide code written while the divider runs is adopted only at the start of the next output high phase, so the output never produces a runt pulse. While the PLL-enable input is low, the divider is parked with its output low.

Top module: `clk_postdiv`

## Requirements
- R1: While hardRstN is low, both registers read 0x00, fbRatio is 0 and baseClk is low.
- R2: Register 0 (regAddr=0) keeps post-divide code bits 3:0 and reads bits 7:4 as zero. Register 1 (regAddr=1) keeps feedback code bits 5:0 and reads bits 7:6 as zero, even after 1s are written to those bits.
- R3: With regRdEn high, regRdData shows the addressed register in the same cycle. With regRdEn low, regRdData is 0x00.
- R4: A write is ignored while clkSel equals 2'b10. Any other clkSel value lets the write land on the next clock edge.
- R5: A soft reset pulse keeps both ratio fields and drops baseClk low for that edge. The divider then restarts with a fresh high phase on the next enabled edge, and any write during the pulse is ignored.
- R6: Post-divide code k gives a period of k+1 source cycles. For an even ratio R, baseClk is high for R/2 cycles and low for R/2 cycles.
- R7: For an odd ratio R of 3 or more, baseClk is high for (R-1)/2 cycles and low for (R+1)/2 cycles.
- R8: Code 0 (ratio 1) passes the source clock straight to baseClk once the divider runs.
- R9: While pllEn is low, baseClk stays low and the divider count stays at zero. The first source edge that samples pllEn high starts a high phase, for ratios of 2 or more.
- R10: A code written while the divider runs takes effect only at the next rising edge of baseClk. The output cycle in progress completes with the old ratio.
- R11: fbRatio always presents the stored feedback code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock; also clocks the register port |
| hardRstN | input | 1 | Asynchronous active-low hard reset (init pin or watchdog) |
| softRst | input | 1 | Synchronous active-high soft reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 1 | 0 selects post-divide register, 1 selects feedback register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational |
| clkSel | input | 2 | Clock-source select; 2'b10 means PLL is the active source |
| pllEn | input | 1 | PLL enable; low parks the divider |
| fbRatio | output | 6 | Feedback ratio code for the external PLL |
| baseClk | output | 1 | Divided base clock |

## Verification
The bench targets the odd ratios, where a divider that splits the period evenly, or that gives the extra cycle to the high phase, produces the wrong high/low counts. It also covers ratio 1, where a divider that counts instead of bypassing would output a flat line. It changes the ratio in the middle of a high phase: a design that adopts the new code at once would cut that phase short. Its remaining targets are a locked write, which a careless write gate would let through, and a soft reset, which a design sharing the hard-reset path would use to wipe the ratio fields.

// File: rtl/clk_postdiv_pkg.sv
package clk_postdiv_pkg;
  localparam int RATIO_W = 4;

  typedef struct packed {
    logic               runEn;
    logic               restart;
    logic [RATIO_W-1:0] ratioCode;
  } divCtrl_t;
endpackage

// File: rtl/clk_postdiv_regs.sv
module clk_postdiv_regs
  import clk_postdiv_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         FB_W     = 6,
  parameter logic [1:0] LOCK_SEL = 2'b10
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [1:0]        clkSel,
  input  logic              pllEn,
  output logic [FB_W-1:0]   fbRatio,
  output divCtrl_t          divCtrl
);
  localparam logic [DATA_W-1:0] POST_MASK = {{(DATA_W-RATIO_W){1'b0}}, {RATIO_W{1'b1}}};
  localparam logic [DATA_W-1:0] FB_MASK   = {{(DATA_W-FB_W){1'b0}}, {FB_W{1'b1}}};

  logic [DATA_W-1:0] postReg;
  logic [DATA_W-1:0] fbReg;
  logic              locked;
  logic              wrOk;

  assign locked = (clkSel == LOCK_SEL);
  assign wrOk   = regWrEn && !softRst && !locked;

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      postReg <= '0;
      fbReg   <= '0;
    end else if (wrOk) begin
      if (!regAddr) postReg <= regWrData & POST_MASK;
      else          fbReg   <= regWrData & FB_MASK;
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRdEn) regRdData = regAddr ? fbReg : postReg;
  end

  assign fbRatio           = fbReg[FB_W-1:0];
  assign divCtrl.runEn     = pllEn;
  assign divCtrl.restart   = softRst;
  assign divCtrl.ratioCode = postReg[RATIO_W-1:0];

  // R4: no register moves on a write issued while the PLL is the source
  assert_locked_write_R4: assert property (@(posedge clk) disable iff (!hardRstN)
    (regWrEn && (clkSel == LOCK_SEL)) |=> ($stable(postReg) && $stable(fbReg)));

  // R5: soft reset never disturbs the stored ratios
  assert_soft_keeps_R5: assert property (@(posedge clk) disable iff (!hardRstN)
    softRst |=> ($stable(postReg) && $stable(fbReg)));
endmodule

// File: rtl/clk_postdiv_core.sv
module clk_postdiv_core
  import clk_postdiv_pkg::*;
(
  input  logic     clk,
  input  logic     hardRstN,
  input  divCtrl_t divCtrl,
  output logic     baseClk
);
  localparam int CNT_W = RATIO_W;

  logic [CNT_W-1:0]   cnt;
  logic [RATIO_W-1:0] activeCode;
  logic               primed;
  logic               divQ;
  logic               wrap;
  logic [CNT_W:0]     cntInc;
  logic [RATIO_W:0]   halfAct;
  logic [RATIO_W:0]   halfNew;

  // high phase length is floor(ratio/2) where ratio = code+1
  assign halfAct = ({1'b0, activeCode} + {{RATIO_W{1'b0}}, 1'b1}) >> 1;
  assign halfNew = ({1'b0, divCtrl.ratioCode} + {{RATIO_W{1'b0}}, 1'b1}) >> 1;
  assign cntInc  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
  assign wrap    = !primed || (cnt == activeCode);

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      cnt        <= '0;
      activeCode <= '0;
      primed     <= 1'b0;
      divQ       <= 1'b0;
    end else if (!divCtrl.runEn || divCtrl.restart) begin
      cnt    <= '0;
      primed <= 1'b0;
      divQ   <= 1'b0;
    end else begin
      primed <= 1'b1;
      if (wrap) begin
        cnt        <= '0;
        activeCode <= divCtrl.ratioCode;
        divQ       <= (halfNew != '0);
      end else begin
        cnt  <= cnt + 1'b1;
        divQ <= (cntInc < halfAct);
      end
    end
  end

  // ratio 1 bypasses the counter
  assign baseClk = (primed && (activeCode == '0)) ? clk : divQ;

  // R9: a parked divider is low with a cleared count
  assert_hold_low_R9: assert property (@(posedge clk) disable iff (!hardRstN)
    !divCtrl.runEn |=> (!divQ && (cnt == '0)));

  // R6: count never passes the last position of the active period
  assert_count_range_R6: assert property (@(posedge clk) disable iff (!hardRstN)
    cnt <= activeCode);

  // R10: the active ratio only changes at a period boundary
  assert_swap_at_edge_R10: assert property (@(posedge clk) disable iff (!hardRstN)
    (primed && divCtrl.runEn && !divCtrl.restart && (cnt != activeCode))
      |=> $stable(activeCode));
endmodule

// File: rtl/clk_postdiv.sv
module clk_postdiv
  import clk_postdiv_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter int         FB_W     = 6,
  parameter logic [1:0] LOCK_SEL = 2'b10
) (
  input  logic              clk,
  input  logic              hardRstN,
  input  logic              softRst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [1:0]        clkSel,
  input  logic              pllEn,
  output logic [FB_W-1:0]   fbRatio,
  output logic              baseClk
);
  divCtrl_t divCtrl;

  clk_postdiv_regs #(
    .DATA_W  (DATA_W),
    .FB_W    (FB_W),
    .LOCK_SEL(LOCK_SEL)
  ) i_regs (
    .clk      (clk),
    .hardRstN (hardRstN),
    .softRst  (softRst),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .clkSel   (clkSel),
    .pllEn    (pllEn),
    .fbRatio  (fbRatio),
    .divCtrl  (divCtrl)
  );

  clk_postdiv_core i_core (
    .clk     (clk),
    .hardRstN(hardRstN),
    .divCtrl (divCtrl),
    .baseClk (baseClk)
  );
endmodule

// File: tb/test_clk_postdiv.sv
`timescale 1ns/1ps
module test_clk_postdiv;
  localparam real CLK_P = 8.0;

  logic       clk = 1'b0;
  logic       hardRstN = 1'b0;
  logic       softRst = 1'b0;
  logic       regWrEn = 1'b0;
  logic       regRdEn = 1'b0;
  logic       regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] clkSel = 2'b00;
  logic       pllEn = 1'b0;
  logic [5:0] fbRatio;
  logic       baseClk;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  clk_postdiv i_clk_postdiv (
    .clk(clk), .hardRstN(hardRstN), .softRst(softRst), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .clkSel(clkSel), .pllEn(pllEn),
    .fbRatio(fbRatio), .baseClk(baseClk)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic writeReg(logic addr, logic [7:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readChk(string req, logic addr, logic [7:0] exp);
    @(negedge clk);
    regAddr = addr; regRdEn = 1'b1;
    #1 chk(req, regRdData, exp);
    regRdEn = 1'b0;
    #1;
  endtask

  task automatic runPattern(string req, int code, int n);
    int r;
    r = code + 1;
    @(negedge clk); pllEn = 1'b0;
    writeReg(1'b0, 8'(code));
    @(negedge clk); pllEn = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
      chk(req, {7'd0, baseClk}, {7'd0, ((i % r) < (r / 2)) ? 1'b1 : 1'b0});
    end
    @(negedge clk); pllEn = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    regRdEn = 1'b1; regAddr = 1'b0;
    #1 chk("R1 post reg", regRdData, 8'h00);
    regAddr = 1'b1;
    #1 chk("R1 fb reg", regRdData, 8'h00);
    regRdEn = 1'b0;
    chk("R1 fbRatio", {2'b0, fbRatio}, 8'h00);
    chk("R1 baseClk", {7'd0, baseClk}, 8'h00);
    repeat (3) @(negedge clk);
    hardRstN = 1'b1;
  endtask

  task automatic t_map();
    writeReg(1'b0, 8'hFF);
    readChk("R2 post field", 1'b0, 8'h0F);
    writeReg(1'b1, 8'hFF);
    readChk("R2 fb field", 1'b1, 8'h3F);
    chk("R11 fbRatio", {2'b0, fbRatio}, 8'h3F);
    writeReg(1'b1, 8'h2A);
    readChk("R3 same-cycle read", 1'b1, 8'h2A);
    chk("R11 fbRatio update", {2'b0, fbRatio}, 8'h2A);
    chk("R3 idle read zero", regRdData, 8'h00);
  endtask

  task automatic t_lock();
    clkSel = 2'b10;
    writeReg(1'b0, 8'h05);
    readChk("R4 locked post", 1'b0, 8'h0F);
    writeReg(1'b1, 8'h01);
    readChk("R4 locked fb", 1'b1, 8'h2A);
    clkSel = 2'b01;
    writeReg(1'b0, 8'h07);
    readChk("R4 unlocked post", 1'b0, 8'h07);
    clkSel = 2'b00;
  endtask

  task automatic t_even();
    runPattern("R6 ratio 2", 1, 8);
    runPattern("R6 ratio 6", 5, 12);
    runPattern("R6 ratio 16", 15, 32);
  endtask

  task automatic t_odd();
    runPattern("R7 ratio 3", 2, 9);
    runPattern("R7 ratio 5", 4, 10);
  endtask

  task automatic t_bypass();
    @(negedge clk); pllEn = 1'b0;
    writeReg(1'b0, 8'h00);
    @(negedge clk); pllEn = 1'b1;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #2;
      chk("R8 bypass high", {7'd0, baseClk}, 8'h01);
      @(negedge clk); #2;
      chk("R8 bypass low", {7'd0, baseClk}, 8'h00);
    end
    @(negedge clk); pllEn = 1'b0;
  endtask

  task automatic t_hold();
    writeReg(1'b0, 8'h03);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      chk("R9 parked low", {7'd0, baseClk}, 8'h00);
    end
    @(negedge clk); pllEn = 1'b1;
    @(posedge clk); #2;
    chk("R9 first enabled edge high", {7'd0, baseClk}, 8'h01);
    @(negedge clk); pllEn = 1'b0;
  endtask

  task automatic t_swap();
    logic [7:0] expTail [6] = '{8'h0, 8'h0, 8'h1, 8'h0, 8'h1, 8'h0};
    writeReg(1'b0, 8'h03);
    @(negedge clk); pllEn = 1'b1;
    @(posedge clk); #2;
    chk("R10 first high", {7'd0, baseClk}, 8'h01);
    @(negedge clk);
    regAddr = 1'b0; regWrData = 8'h01; regWrEn = 1'b1;
    @(posedge clk); #2;
    chk("R10 old high phase kept", {7'd0, baseClk}, 8'h01);
    @(negedge clk); regWrEn = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #2;
      chk("R10 swap at rising edge", {7'd0, baseClk}, expTail[i]);
    end
    @(negedge clk); pllEn = 1'b0;
  endtask

  task automatic t_soft();
    writeReg(1'b0, 8'h03);
    writeReg(1'b1, 8'h15);
    @(negedge clk); pllEn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk); softRst = 1'b1;
    regAddr = 1'b0; regWrData = 8'h09; regWrEn = 1'b1;
    @(posedge clk); #2;
    chk("R5 soft reset drops output", {7'd0, baseClk}, 8'h00);
    @(negedge clk); softRst = 1'b0; regWrEn = 1'b0;
    @(posedge clk); #2;
    chk("R5 restart high", {7'd0, baseClk}, 8'h01);
    @(negedge clk); pllEn = 1'b0;
    readChk("R5 post kept", 1'b0, 8'h03);
    readChk("R5 fb kept", 1'b1, 8'h15);
  endtask

  task automatic t_hard();
    @(negedge clk); pllEn = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); hardRstN = 1'b0;
    #1;
    chk("R1 hard reset output", {7'd0, baseClk}, 8'h00);
    chk("R1 hard reset fbRatio", {2'b0, fbRatio}, 8'h00);
    regRdEn = 1'b1; regAddr = 1'b0;
    #1 chk("R1 hard reset post", regRdData, 8'h00);
    regRdEn = 1'b0; pllEn = 1'b0;
    @(negedge clk); hardRstN = 1'b1;
  endtask

  initial begin
    t_reset();
    t_map();
    t_lock();
    t_even();
    t_odd();
    t_bypass();
    t_hold();
    t_swap();
    t_soft();
    t_hard();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule